// File: doc/BRIEF.md
# Test Mode Controller and Pin Mux

This block chooses the chip's test mode from two active-low test pins and from the level of the user reset pin as it stood when power-on reset was released. From that mode it overrides pad output enables, observes pins, or steers internal clocks onto pins. Four modes exist. Normal operation applies no overrides. Debug mode enables the CPU debug logic. High-impedance mode switches off every pad output enable with no clock involved. Oscillator/PLL observation mode turns four port A pins into PLL control inputs and five column pins into clock monitor outputs.

A second, software-controlled feature is enabled by one bit of the system control word. While that bit is set, each internal peripheral-bus access is copied onto the external address and data bus, and chip-select 5 strobes for it. Chip-select 5 also keeps strobing for its own address range. Three port E pins show the gated CPU clock and both interrupt request lines. A warning output flags the case where this feature and LCD DMA are enabled together, because both could then drive the external bus.

There are no streaming transfers here. Every pin is a plain level with no handshake. The pads, the PLL and the CPU sit outside the block.

Top module: `test_mode_ctrl`

## Requirements
- R1: The level of `usr_rst_n` is captured on the first rising `clk` edge after `por_n` goes high. It is held until the next power-on reset. Later changes of `usr_rst_n` do not change the mode. During power-on reset the held level reads 0.
- R2: When `test0_n` is 1, the mode is normal. `dbg_en` is 0. Every output and output enable follows its normal-path input. The PLL controls take their defaults: `pll_tsel`=0, `osc_on`=1, `pll_on`=1, `pll_byp`=0.
- R3: When `test0_n`=0, `test1_n`=0 and the held level is 1, `dbg_en` is 1 and no pad override applies. In every other mode `dbg_en` is 0.
- R4: When `test0_n`=0, `test1_n`=0 and the held level is 0, `pa_oe`, `pe_oe`, `col_oe` and `xbus_oe` are all 0. This happens combinationally, within the same cycle. The output values themselves are unchanged, and leaving the mode restores the enables with no other effect.
- R5: When `test0_n`=0 and `test1_n`=1 (oscillator/PLL mode), `pa_in` bits 5, 4, 3 and 0 drive `pll_tsel`, `osc_on`, `pll_on` and `pll_byp` respectively, and those `pa_oe` bits are forced to 0.
- R6: In oscillator/PLL mode, `col_out` bits 0, 1, 2, 4 and 6 carry `rtc_osc`, `rtc_1hz`, `clk36`, `clk576k` and `pll_tclk` respectively, and their `col_oe` bits are 1. The other column bits follow their normal inputs.
- R7: When `sysctl` bit 11 is 1 and `pbus_req` is 1, `xbus_addr`/`xbus_wdata` show `pbus_addr`/`pbus_wdata` and `xbus_cs5_n` is 0. `xbus_oe` is 1 for a write (`pbus_wr`=1). In all other cases the bus outputs pass `ext_addr`, `ext_wdata` and `ext_bus_oe`. No other `sysctl` bit has any effect.
- R8: `xbus_cs5_n` is 0 whenever `ext_cs5_sel` is 1, whatever the state of bit 11.
- R9: While `sysctl` bit 11 is 1, `pe_out` bits 0, 1 and 2 carry `cpu_clk_gated`, `fiq_n` and `irq_n` respectively, and their `pe_oe` bits are 1. While the bit is 0 they follow `pe_gpio_out`/`pe_gpio_oe`.
- R10: `contention_warn` is 1 exactly when `sysctl` bit 11 and `lcd_dma_en` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the reset-level capture |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| test0_n | input | 1 | Test select pin 0, active low |
| test1_n | input | 1 | Test select pin 1, active low |
| usr_rst_n | input | 1 | User reset pin level, sampled after power-on |
| sysctl | input | 32 | System control word; bit 11 enables software test |
| lcd_dma_en | input | 1 | LCD DMA enabled |
| pbus_req | input | 1 | Internal peripheral-bus access in progress |
| pbus_wr | input | 1 | Peripheral access is a write |
| pbus_addr | input | 32 | Peripheral access address |
| pbus_wdata | input | 32 | Peripheral access data |
| ext_addr | input | 32 | Memory-controller address |
| ext_wdata | input | 32 | Memory-controller data |
| ext_cs5_sel | input | 1 | Memory controller targets the chip-select 5 range |
| ext_bus_oe | input | 1 | Memory-controller bus output enable |
| xbus_addr | output | 32 | External address bus |
| xbus_wdata | output | 32 | External data bus |
| xbus_cs5_n | output | 1 | Chip-select 5, active low |
| xbus_oe | output | 1 | External bus output enable |
| pe_gpio_out | input | 8 | Port E normal output values |
| pe_gpio_oe | input | 8 | Port E normal output enables |
| cpu_clk_gated | input | 1 | Gated CPU clock |
| fiq_n | input | 1 | Fast interrupt request to CPU |
| irq_n | input | 1 | Normal interrupt request to CPU |
| pe_out | output | 8 | Port E pad output values |
| pe_oe | output | 8 | Port E pad output enables |
| pa_in | input | 8 | Port A pad input values |
| pa_oe_norm | input | 8 | Port A normal output enables |
| pa_oe | output | 8 | Port A pad output enables |
| pll_tsel | output | 1 | PLL test select |
| osc_on | output | 1 | Oscillator enable |
| pll_on | output | 1 | PLL enable |
| pll_byp | output | 1 | PLL bypass |
| col_norm | input | 8 | Column normal output values |
| col_oe_norm | input | 8 | Column normal output enables |
| rtc_osc | input | 1 | RTC oscillator clock |
| rtc_1hz | input | 1 | RTC 1 Hz divider output |
| clk36 | input | 1 | Divided PLL main clock |
| clk576k | input | 1 | 576 kHz derived clock |
| pll_tclk | input | 1 | PLL test clock |
| col_out | output | 8 | Column pad output values |
| col_oe | output | 8 | Column pad output enables |
| dbg_en | output | 1 | Debug enable to CPU |
| contention_warn | output | 1 | Software test and LCD DMA both enabled |

## Verification
The bench runs two power-on sequences, one with the user reset pin high and one with it low, so that the same pin code both low is seen to decode as debug mode and as high-impedance mode. Random test-pin codes, random control words with bit 11 set or clear, random bus traffic and random pad values are each checked against models built from the requirements, which separates the normal path from each kind of override. Directed cases toggle the user reset pin after capture, enter high-impedance mode half way through a clock period, and combine chip-select 5 range hits with mirrored accesses.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
  typedef enum logic [3:0] {
    M_NORMAL = 4'b0001,
    M_DEBUG  = 4'b0010,
    M_HIZ    = 4'b0100,
    M_OSC    = 4'b1000
  } tmc_mode_e;

  // port A pins used as PLL controls in oscillator/PLL mode
  localparam int PA_TSEL = 5;
  localparam int PA_OSC  = 4;
  localparam int PA_PLL  = 3;
  localparam int PA_BYP  = 0;

  // column pins carrying clocks in oscillator/PLL mode
  localparam int COL_RTC  = 0;
  localparam int COL_1HZ  = 1;
  localparam int COL_36M  = 2;
  localparam int COL_576K = 4;
  localparam int COL_TCLK = 6;

  // port E pins used by the software test feature
  localparam int PE_CLK = 0;
  localparam int PE_FIQ = 1;
  localparam int PE_IRQ = 2;
  localparam int PE_TEST_BITS = 3;
endpackage

// File: rtl/tmc_mode_decode.sv
module tmc_mode_decode
  import tmc_pkg::*;
(
  input  logic      clk,
  input  logic      por_n,
  input  logic      test0_n,
  input  logic      test1_n,
  input  logic      usr_rst_n,
  output tmc_mode_e mode,
  output logic      lvl_q,
  output logic      cap_done
);
  // one-shot capture of the user reset level after power-on release
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lvl_q    <= 1'b0;
      cap_done <= 1'b0;
    end else if (!cap_done) begin
      lvl_q    <= usr_rst_n;
      cap_done <= 1'b1;
    end
  end

  // purely combinational so the high-impedance override needs no clock
  always_comb begin
    if (test0_n)      mode = M_NORMAL;
    else if (test1_n) mode = M_OSC;
    else if (lvl_q)   mode = M_DEBUG;
    else              mode = M_HIZ;
  end
endmodule

// File: rtl/tmc_swtest_mux.sv
module tmc_swtest_mux
  import tmc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PE_W   = 8
) (
  input  logic              mirror_en,
  input  logic              pbus_req,
  input  logic              pbus_wr,
  input  logic [ADDR_W-1:0] pbus_addr,
  input  logic [DATA_W-1:0] pbus_wdata,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [DATA_W-1:0] ext_wdata,
  input  logic              ext_cs5_sel,
  input  logic              ext_bus_oe,
  input  logic [PE_W-1:0]   pe_gpio_out,
  input  logic [PE_W-1:0]   pe_gpio_oe,
  input  logic              cpu_clk_gated,
  input  logic              fiq_n,
  input  logic              irq_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_cs5_n,
  output logic              bus_oe_raw,
  output logic [PE_W-1:0]   pe_out,
  output logic [PE_W-1:0]   pe_oe_raw
);
  logic mirror_act;
  logic [PE_TEST_BITS-1:0] test_sig;

  assign mirror_act = mirror_en & pbus_req;
  assign bus_addr   = mirror_act ? pbus_addr  : ext_addr;
  assign bus_wdata  = mirror_act ? pbus_wdata : ext_wdata;
  assign bus_cs5_n  = ~(ext_cs5_sel | mirror_act);
  assign bus_oe_raw = ext_bus_oe | (mirror_act & pbus_wr);

  always_comb begin
    test_sig         = '0;
    test_sig[PE_CLK] = cpu_clk_gated;
    test_sig[PE_FIQ] = fiq_n;
    test_sig[PE_IRQ] = irq_n;
  end

  for (genvar i = 0; i < PE_W; i++) begin : g_pe
    if (i < PE_TEST_BITS) begin : g_test
      assign pe_out[i]    = mirror_en ? test_sig[i] : pe_gpio_out[i];
      assign pe_oe_raw[i] = mirror_en | pe_gpio_oe[i];
    end else begin : g_plain
      assign pe_out[i]    = pe_gpio_out[i];
      assign pe_oe_raw[i] = pe_gpio_oe[i];
    end
  end
endmodule

// File: rtl/tmc_pad_override.sv
module tmc_pad_override
  import tmc_pkg::*;
#(
  parameter int PA_W  = 8,
  parameter int PE_W  = 8,
  parameter int COL_W = 8
) (
  input  tmc_mode_e        mode,
  input  logic [PA_W-1:0]  pa_in,
  input  logic [PA_W-1:0]  pa_oe_norm,
  input  logic [COL_W-1:0] col_norm,
  input  logic [COL_W-1:0] col_oe_norm,
  input  logic             rtc_osc,
  input  logic             rtc_1hz,
  input  logic             clk36,
  input  logic             clk576k,
  input  logic             pll_tclk,
  input  logic             bus_oe_raw,
  input  logic [PE_W-1:0]  pe_oe_raw,
  output logic [PA_W-1:0]  pa_oe,
  output logic [PE_W-1:0]  pe_oe,
  output logic [COL_W-1:0] col_out,
  output logic [COL_W-1:0] col_oe,
  output logic             xbus_oe,
  output logic             pll_tsel,
  output logic             osc_on,
  output logic             pll_on,
  output logic             pll_byp
);
  logic osc_m, hiz_m;
  logic [PA_W-1:0]  pa_mask;
  logic [COL_W-1:0] col_mask, col_clk;
  logic [PA_W-1:0]  pa_unused;

  assign osc_m = (mode == M_OSC);
  assign hiz_m = (mode == M_HIZ);
  assign pa_unused = pa_in & ~pa_mask;

  always_comb begin
    pa_mask = '0;
    pa_mask[PA_TSEL] = 1'b1;
    pa_mask[PA_OSC]  = 1'b1;
    pa_mask[PA_PLL]  = 1'b1;
    pa_mask[PA_BYP]  = 1'b1;
    col_mask = '0;
    col_clk  = '0;
    col_mask[COL_RTC]  = 1'b1; col_clk[COL_RTC]  = rtc_osc;
    col_mask[COL_1HZ]  = 1'b1; col_clk[COL_1HZ]  = rtc_1hz;
    col_mask[COL_36M]  = 1'b1; col_clk[COL_36M]  = clk36;
    col_mask[COL_576K] = 1'b1; col_clk[COL_576K] = clk576k;
    col_mask[COL_TCLK] = 1'b1; col_clk[COL_TCLK] = pll_tclk;
  end

  // PLL controls: pad inputs in test mode, fixed defaults otherwise
  assign pll_tsel = osc_m ?  pa_in[PA_TSEL] : 1'b0;
  assign osc_on   = osc_m ?  pa_in[PA_OSC]  : 1'b1;
  assign pll_on   = osc_m ?  pa_in[PA_PLL]  : 1'b1;
  assign pll_byp  = osc_m ?  pa_in[PA_BYP]  : 1'b0;

  for (genvar i = 0; i < PA_W; i++) begin : g_pa
    assign pa_oe[i] = ~hiz_m & pa_oe_norm[i] & ~(osc_m & pa_mask[i]);
  end

  for (genvar i = 0; i < COL_W; i++) begin : g_col
    logic sel;
    assign sel       = osc_m & col_mask[i];
    assign col_out[i] = sel ? col_clk[i] : col_norm[i];
    assign col_oe[i]  = ~hiz_m & (sel | col_oe_norm[i]);
  end

  assign pe_oe   = hiz_m ? '0 : pe_oe_raw;
  assign xbus_oe = ~hiz_m & bus_oe_raw;
endmodule

// File: rtl/test_mode_ctrl.sv
module test_mode_ctrl
  import tmc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SYSCTL_W   = 32,
  parameter int MIRROR_BIT = 11,
  parameter int PA_W       = 8,
  parameter int PE_W       = 8,
  parameter int COL_W      = 8
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                test0_n,
  input  logic                test1_n,
  input  logic                usr_rst_n,
  input  logic [SYSCTL_W-1:0] sysctl,
  input  logic                lcd_dma_en,
  input  logic                pbus_req,
  input  logic                pbus_wr,
  input  logic [ADDR_W-1:0]   pbus_addr,
  input  logic [DATA_W-1:0]   pbus_wdata,
  input  logic [ADDR_W-1:0]   ext_addr,
  input  logic [DATA_W-1:0]   ext_wdata,
  input  logic                ext_cs5_sel,
  input  logic                ext_bus_oe,
  output logic [ADDR_W-1:0]   xbus_addr,
  output logic [DATA_W-1:0]   xbus_wdata,
  output logic                xbus_cs5_n,
  output logic                xbus_oe,
  input  logic [PE_W-1:0]     pe_gpio_out,
  input  logic [PE_W-1:0]     pe_gpio_oe,
  input  logic                cpu_clk_gated,
  input  logic                fiq_n,
  input  logic                irq_n,
  output logic [PE_W-1:0]     pe_out,
  output logic [PE_W-1:0]     pe_oe,
  input  logic [PA_W-1:0]     pa_in,
  input  logic [PA_W-1:0]     pa_oe_norm,
  output logic [PA_W-1:0]     pa_oe,
  output logic                pll_tsel,
  output logic                osc_on,
  output logic                pll_on,
  output logic                pll_byp,
  input  logic [COL_W-1:0]    col_norm,
  input  logic [COL_W-1:0]    col_oe_norm,
  input  logic                rtc_osc,
  input  logic                rtc_1hz,
  input  logic                clk36,
  input  logic                clk576k,
  input  logic                pll_tclk,
  output logic [COL_W-1:0]    col_out,
  output logic [COL_W-1:0]    col_oe,
  output logic                dbg_en,
  output logic                contention_warn
);
  tmc_mode_e mode;
  logic usr_lvl, cap_done, mirror_en, bus_oe_raw;
  logic [PE_W-1:0] pe_oe_raw;
  logic sysctl_unused;

  assign mirror_en       = sysctl[MIRROR_BIT];
  assign sysctl_unused   = ^sysctl;
  assign dbg_en          = (mode == M_DEBUG);
  assign contention_warn = mirror_en & lcd_dma_en;

  tmc_mode_decode i_dec (
    .clk(clk), .por_n(por_n), .test0_n(test0_n), .test1_n(test1_n),
    .usr_rst_n(usr_rst_n), .mode(mode), .lvl_q(usr_lvl), .cap_done(cap_done)
  );

  tmc_swtest_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PE_W(PE_W)) i_sw (
    .mirror_en(mirror_en), .pbus_req(pbus_req), .pbus_wr(pbus_wr),
    .pbus_addr(pbus_addr), .pbus_wdata(pbus_wdata),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_cs5_sel(ext_cs5_sel),
    .ext_bus_oe(ext_bus_oe), .pe_gpio_out(pe_gpio_out), .pe_gpio_oe(pe_gpio_oe),
    .cpu_clk_gated(cpu_clk_gated), .fiq_n(fiq_n), .irq_n(irq_n),
    .bus_addr(xbus_addr), .bus_wdata(xbus_wdata), .bus_cs5_n(xbus_cs5_n),
    .bus_oe_raw(bus_oe_raw), .pe_out(pe_out), .pe_oe_raw(pe_oe_raw)
  );

  tmc_pad_override #(.PA_W(PA_W), .PE_W(PE_W), .COL_W(COL_W)) i_pad (
    .mode(mode), .pa_in(pa_in), .pa_oe_norm(pa_oe_norm),
    .col_norm(col_norm), .col_oe_norm(col_oe_norm),
    .rtc_osc(rtc_osc), .rtc_1hz(rtc_1hz), .clk36(clk36), .clk576k(clk576k),
    .pll_tclk(pll_tclk), .bus_oe_raw(bus_oe_raw), .pe_oe_raw(pe_oe_raw),
    .pa_oe(pa_oe), .pe_oe(pe_oe), .col_out(col_out), .col_oe(col_oe),
    .xbus_oe(xbus_oe), .pll_tsel(pll_tsel), .osc_on(osc_on),
    .pll_on(pll_on), .pll_byp(pll_byp)
  );
endmodule

// File: rtl/tmc_checker.sv
module tmc_checker #(
  parameter int ADDR_W = 32,
  parameter int PA_W   = 8,
  parameter int PE_W   = 8,
  parameter int COL_W  = 8
) (
  input logic              clk,
  input logic              por_n,
  input logic              test0_n,
  input logic              test1_n,
  input logic              usr_lvl,
  input logic              cap_done,
  input logic              mirror,
  input logic              lcd_dma_en,
  input logic              pbus_req,
  input logic [ADDR_W-1:0] pbus_addr,
  input logic [ADDR_W-1:0] xbus_addr,
  input logic              xbus_cs5_n,
  input logic              xbus_oe,
  input logic [2:0]        pe_tst,
  input logic              cpu_clk_gated,
  input logic              fiq_n,
  input logic              irq_n,
  input logic [PA_W-1:0]   pa_oe,
  input logic [PE_W-1:0]   pe_oe,
  input logic [COL_W-1:0]  col_oe,
  input logic              dbg_en,
  input logic              contention_warn
);
  p_lvl_hold_r1: assert property (@(posedge clk) disable iff (!por_n)
    cap_done |=> $stable(usr_lvl));

  p_normal_nodbg_r2: assert property (@(posedge clk) disable iff (!por_n)
    test0_n |-> !dbg_en);

  p_debug_code_r3: assert property (@(posedge clk) disable iff (!por_n)
    dbg_en |-> (!test0_n && !test1_n && usr_lvl));

  p_hiz_oe_off_r4: assert property (@(posedge clk) disable iff (!por_n)
    (!test0_n && !test1_n && !usr_lvl) |->
      (pa_oe == '0 && pe_oe == '0 && col_oe == '0 && !xbus_oe));

  p_osc_pa_input_r5: assert property (@(posedge clk) disable iff (!por_n)
    (!test0_n && test1_n) |-> (!pa_oe[5] && !pa_oe[4] && !pa_oe[3] && !pa_oe[0]));

  p_mirror_cs5_r7: assert property (@(posedge clk) disable iff (!por_n)
    (mirror && pbus_req) |-> (!xbus_cs5_n && xbus_addr == pbus_addr));

  p_pe_route_r9: assert property (@(posedge clk) disable iff (!por_n)
    mirror |-> (pe_tst == {irq_n, fiq_n, cpu_clk_gated}));

  p_warn_r10: assert property (@(posedge clk) disable iff (!por_n)
    contention_warn |-> (mirror && lcd_dma_en));
endmodule

bind test_mode_ctrl tmc_checker #(
  .ADDR_W(ADDR_W), .PA_W(PA_W), .PE_W(PE_W), .COL_W(COL_W)
) i_tmc_checker (
  .clk(clk), .por_n(por_n), .test0_n(test0_n), .test1_n(test1_n),
  .usr_lvl(usr_lvl), .cap_done(cap_done), .mirror(sysctl[MIRROR_BIT]),
  .lcd_dma_en(lcd_dma_en), .pbus_req(pbus_req), .pbus_addr(pbus_addr),
  .xbus_addr(xbus_addr), .xbus_cs5_n(xbus_cs5_n), .xbus_oe(xbus_oe),
  .pe_tst(pe_out[2:0]), .cpu_clk_gated(cpu_clk_gated), .fiq_n(fiq_n),
  .irq_n(irq_n), .pa_oe(pa_oe), .pe_oe(pe_oe), .col_oe(col_oe),
  .dbg_en(dbg_en), .contention_warn(contention_warn)
);

// File: tb/test_test_mode_ctrl.sv
`timescale 1ns/1ps
module test_test_mode_ctrl;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic por_n, test0_n, test1_n, usr_rst_n, lcd_dma_en;
  logic [31:0] sysctl, pbus_addr, pbus_wdata, ext_addr, ext_wdata;
  logic pbus_req, pbus_wr, ext_cs5_sel, ext_bus_oe;
  logic [31:0] xbus_addr, xbus_wdata;
  logic xbus_cs5_n, xbus_oe;
  logic [7:0] pe_gpio_out, pe_gpio_oe, pe_out, pe_oe;
  logic cpu_clk_gated, fiq_n, irq_n;
  logic [7:0] pa_in, pa_oe_norm, pa_oe, col_norm, col_oe_norm, col_out, col_oe;
  logic pll_tsel, osc_on, pll_on, pll_byp;
  logic rtc_osc, rtc_1hz, clk36, clk576k, pll_tclk;
  logic dbg_en, contention_warn;

  test_mode_ctrl i_test_mode_ctrl (.*);

  int checks = 0, failures = 0;
  logic lvl_exp;
  bit done = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_pa_oe(logic osc, logic hiz);
    if (hiz) return 8'h00;
    return osc ? (pa_oe_norm & ~8'b0011_1001) : pa_oe_norm;
  endfunction

  function automatic logic [7:0] exp_col(logic osc);
    logic [7:0] c = col_norm;
    if (osc) begin
      c[0] = rtc_osc; c[1] = rtc_1hz; c[2] = clk36; c[4] = clk576k; c[6] = pll_tclk;
    end
    return c;
  endfunction

  task automatic check_all();
    logic osc, hiz, dbg, mir, act;
    logic [7:0] peo, peoe;
    osc = !test0_n && test1_n;
    hiz = !test0_n && !test1_n && !lvl_exp;
    dbg = !test0_n && !test1_n && lvl_exp;
    mir = sysctl[11];
    act = mir && pbus_req;
    peo = pe_gpio_out; peoe = pe_gpio_oe;
    if (mir) begin peo[2:0] = {irq_n, fiq_n, cpu_clk_gated}; peoe[2:0] = 3'b111; end
    if (hiz) peoe = 8'h00;
    chk(dbg ? "R3 dbg_en" : "R2 dbg_en", dbg_en, dbg);
    chk("R5 pll ctrl", {pll_tsel, osc_on, pll_on, pll_byp},
        osc ? {pa_in[5], pa_in[4], pa_in[3], pa_in[0]} : 4'b0110);
    chk(hiz ? "R4 pa_oe" : "R5 pa_oe", pa_oe, exp_pa_oe(osc, hiz));
    chk("R6 col_out", col_out, exp_col(osc));
    chk(hiz ? "R4 col_oe" : "R6 col_oe", col_oe,
        hiz ? 8'h00 : (col_oe_norm | (osc ? 8'b0101_0111 : 8'h00)));
    chk("R7 xbus_addr", xbus_addr, act ? pbus_addr : ext_addr);
    chk("R7 xbus_wdata", xbus_wdata, act ? pbus_wdata : ext_wdata);
    chk("R8 xbus_cs5_n", xbus_cs5_n, !(ext_cs5_sel || act));
    chk(hiz ? "R4 xbus_oe" : "R7 xbus_oe", xbus_oe,
        !hiz && (ext_bus_oe || (act && pbus_wr)));
    chk("R9 pe_out", pe_out, peo);
    chk(hiz ? "R4 pe_oe" : "R9 pe_oe", pe_oe, peoe);
    chk("R10 contention_warn", contention_warn, mir && lcd_dma_en);
  endtask

  task automatic rand_inputs(bit pins);
    if (pins) {test0_n, test1_n} = 2'($urandom);
    sysctl = $urandom; lcd_dma_en = 1'($urandom);
    pbus_req = 1'($urandom); pbus_wr = 1'($urandom);
    pbus_addr = $urandom; pbus_wdata = $urandom;
    ext_addr = $urandom; ext_wdata = $urandom;
    ext_cs5_sel = 1'($urandom); ext_bus_oe = 1'($urandom);
    pe_gpio_out = 8'($urandom); pe_gpio_oe = 8'($urandom);
    {cpu_clk_gated, fiq_n, irq_n} = 3'($urandom);
    pa_in = 8'($urandom); pa_oe_norm = 8'($urandom);
    col_norm = 8'($urandom); col_oe_norm = 8'($urandom);
    {rtc_osc, rtc_1hz, clk36, clk576k, pll_tclk} = 5'($urandom);
  endtask

  task automatic power_on(logic lvl);
    por_n = 1'b0; usr_rst_n = lvl;
    repeat (3) @(posedge clk);
    #2 por_n = 1'b1;
    @(posedge clk);   // capture edge (R1)
    #1 usr_rst_n = ~lvl;
    lvl_exp = lvl;
    @(posedge clk); #2;
  endtask

  task automatic rand_phase(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      rand_inputs(1'b1);
      usr_rst_n = 1'($urandom);   // R1: ignored after capture
      #2 check_all();
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_7a11));
    test0_n = 1; test1_n = 1; rand_inputs(1'b0);
    por_n = 0; usr_rst_n = 1;
    #1;
    // R1: held level reads 0 during power-on reset -> both pins low is hi-z
    test0_n = 0; test1_n = 0; lvl_exp = 0; #1;
    chk("R1 reset level", {dbg_en, pa_oe == 8'h00}, 2'b01);
    test0_n = 1; test1_n = 1;

    // power-on with user reset high
    power_on(1'b1);
    chk("R2 normal after reset", {dbg_en, pll_tsel, osc_on, pll_on, pll_byp}, 5'b00110);
    test0_n = 0; test1_n = 0; #1;
    chk("R3 debug enable", dbg_en, 1'b1);
    usr_rst_n = 0; @(posedge clk); @(posedge clk); #2;
    chk("R1 level held after pin change", dbg_en, 1'b1);
    rand_phase(300);

    // directed mirror and chip-select 5 cases
    @(posedge clk); #2;
    test0_n = 1; sysctl = 32'h0000_0800; pbus_req = 1; pbus_wr = 1;
    ext_cs5_sel = 0; ext_bus_oe = 0; #1;
    chk("R7 mirror cs5", {xbus_cs5_n, xbus_oe}, 2'b01);
    check_all();
    sysctl = 32'hFFFF_F7FF; #1;
    chk("R7 other sysctl bits ignored", {xbus_cs5_n, xbus_addr == ext_addr}, 2'b11);
    pbus_req = 0; ext_cs5_sel = 1; #1;
    chk("R8 cs5 own range", xbus_cs5_n, 1'b0);
    sysctl = 32'h0000_0800; lcd_dma_en = 1; #1;
    chk("R10 warn", contention_warn, 1'b1);

    // power-on with user reset low
    power_on(1'b0);
    rand_inputs(1'b0);
    test0_n = 1; test1_n = 1; #1;
    check_all();
    @(posedge clk); #4;   // mid-cycle entry shows the override needs no edge
    test0_n = 0; test1_n = 0; #1;
    chk("R4 hiz immediate", {pa_oe, pe_oe, col_oe, xbus_oe}, 25'd0);
    chk("R4 values kept", col_out, col_norm);
    chk("R3 no debug in hiz", dbg_en, 1'b0);
    #1 test0_n = 1; #1;
    check_all();
    rand_phase(300);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule